// File: doc/BRIEF.md
# Receive descriptor ring engine

This block keeps the ownership state of a circular ring of 16-byte receive descriptors that live in host memory. Software programs the ring's base address and byte length through a small register window, then hands descriptors to hardware by moving the tail index forward. Hardware owns every slot from the head index up to, but not including, the tail. When a frame finishes, the engine takes the slot at the head and emits a write-back word holding the frame's length, checksum, status, errors and VLAN tag, together with the host address it must land at. It then moves the head forward and wraps it at the end of the ring.

The DMA mover and the MAC sit outside this block. The DMA mover uses the descriptor address output to fetch the buffer pointer of the next free slot, and it uses the write-back address and data to store the completion record. A frame that arrives while hardware owns no slot is dropped and counted.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the control, length, head and tail registers read 0. `wb_valid_o`, `drop_o` and `desc_avail_o` are low, and the miss count is 0.
- R2: The register window has these offsets. Control is at 0x0100, with receive enable at bit 1. Ring base low is at 0x2800 and keeps bits 31:4, with bits 3:0 reading 0. Ring base high is at 0x2804. Ring byte length is at 0x2808 and keeps bits IDX_W+3:7, with bits 6:0 reading 0. Head is at 0x2810 and tail is at 0x2818, each in bits IDX_W-1:0. Other offsets read 0.
- R3: A length write whose bits IDX_W+3:7 are all zero (below 128 bytes) is ignored. An accepted length write clears head and tail to 0. The slot count is the byte length divided by 16.
- R4: While receive enable is set, writes to base low, base high, length and head are ignored. Tail stays writable.
- R5: A head or tail write whose index is not below the slot count is ignored.
- R6: A frame arriving while enabled, with head not equal to tail, is accepted. One cycle later `wb_valid_o` pulses, and `wb_addr_o` equals base + 16*head + 8, using the head before the frame. The head then advances.
- R7: The write-back word packs the fields as follows: length at bits 15:0, checksum at 31:16, status at 39:32, errors at 47:40 and VLAN at 63:48. Status bit 0 (done) and bit 1 (end of packet) are forced to 1, and the other status bits pass through. Error bits 3 and 4 are forced to 0, and the other error bits pass through.
- R8: The head wraps from slot count - 1 to 0.
- R9: A frame arriving while enabled, with head equal to tail, gives no write-back and leaves the head unchanged. One cycle later `drop_o` pulses and the miss count has risen by one.
- R10: A frame arriving while receive enable is clear is ignored. It gives no write-back, no drop and no change in the miss count.
- R11: `desc_addr_o` equals base + 16*head at all times. `desc_avail_o` is high exactly when enable is set and head differs from tail.
- R12: When a tail write and a frame arrive in the same cycle, ring emptiness is judged on the tail value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| frame_valid_i | input | 1 | One-cycle pulse: a received frame is complete |
| frame_len_i | input | 16 | Frame length in bytes |
| frame_csum_i | input | 16 | Frame checksum |
| frame_status_i | input | 8 | Status flags; bits 1:0 are replaced |
| frame_err_i | input | 8 | Error flags; bits 4:3 are cleared |
| frame_vlan_i | input | 16 | VLAN tag |
| desc_addr_o | output | 64 | Host byte address of the head descriptor |
| desc_avail_o | output | 1 | Hardware owns at least one descriptor |
| wb_valid_o | output | 1 | Write-back record valid |
| wb_addr_o | output | 64 | Host byte address of the write-back record |
| wb_data_o | output | 64 | Write-back record (descriptor bytes 8..15) |
| drop_o | output | 1 | Frame dropped because no descriptor was free |
| miss_cnt_o | output | MISS_W | Count of dropped frames |

## Verification
A software tail update and a frame completion can land in the same clock edge while the ring is empty. The bench provokes this by driving the tail write and the frame pulse in one cycle, at the moment its model predicts head equals tail. It then expects a drop and no write-back, followed by a readback of the new tail. After that, a following frame must be accepted at the old head address. The bench also sweeps several ring sizes, including one that is not a power of two. For each size it runs frames across the wrap point until the ring is drained, and it compares each address and record against arithmetic in the bench.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam logic [15:0] OFS_CTRL    = 16'h0100;
  localparam logic [15:0] OFS_BASE_LO = 16'h2800;
  localparam logic [15:0] OFS_BASE_HI = 16'h2804;
  localparam logic [15:0] OFS_LEN     = 16'h2808;
  localparam logic [15:0] OFS_HEAD    = 16'h2810;
  localparam logic [15:0] OFS_TAIL    = 16'h2818;

  localparam int CTRL_EN_BIT = 1;
  localparam logic [7:0] STAT_FORCE_SET = 8'h03;  // done, end of packet
  localparam logic [7:0] ERR_KEEP_MASK  = 8'hE7;  // bits 4:3 reserved

  typedef struct packed {
    logic [15:0] vlan;
    logic [7:0]  errors;
    logic [7:0]  status;
    logic [15:0] csum;
    logic [15:0] length;
  } wb_rec_t;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [15:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [IDX_W-1:0] head_i,
  input  logic [IDX_W-1:0] tail_i,
  output logic             en_o,
  output logic [63:0]      base_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             len_wr_o,
  output logic             head_wr_o,
  output logic             tail_wr_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  localparam int BLK_W = IDX_W - 3;

  logic             en_q;
  logic [27:0]      base_lo_q;
  logic [31:0]      base_hi_q;
  logic [BLK_W-1:0] blk_q;
  logic [BLK_W-1:0] blk_new;
  logic             idx_ok;

  assign blk_new  = wdata_i[IDX_W+3:7];
  assign wr_idx_o = wdata_i[IDX_W-1:0];
  assign cnt_o    = {blk_q, 3'b000};
  assign idx_ok   = wr_idx_o < cnt_o;

  assign len_wr_o  = we_i && !en_q && addr_i == OFS_LEN && blk_new != '0;
  assign head_wr_o = we_i && !en_q && addr_i == OFS_HEAD && idx_ok;
  assign tail_wr_o = we_i && addr_i == OFS_TAIL && idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      blk_q     <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_CTRL) en_q <= wdata_i[CTRL_EN_BIT];
      if (!en_q && addr_i == OFS_BASE_LO) base_lo_q <= wdata_i[31:4];
      if (!en_q && addr_i == OFS_BASE_HI) base_hi_q <= wdata_i;
      if (len_wr_o) blk_q <= blk_new;
    end
  end

  assign en_o   = en_q;
  assign base_o = {base_hi_q, base_lo_q, 4'b0000};

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL:    rdata_o[CTRL_EN_BIT] = en_q;
      OFS_BASE_LO: rdata_o = {base_lo_q, 4'b0000};
      OFS_BASE_HI: rdata_o = base_hi_q;
      OFS_LEN:     rdata_o = 32'({blk_q, 7'b0000000});
      OFS_HEAD:    rdata_o = 32'(head_i);
      OFS_TAIL:    rdata_o = 32'(tail_i);
      default:     rdata_o = '0;
    endcase
  end

  // R4
  base_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> ($stable(base_lo_q) && $stable(base_hi_q) && $stable(blk_q)));
  // R3
  len_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(blk_q) |-> blk_q != '0);
endmodule

// File: rtl/rx_ring_ptrs.sv
module rx_ring_ptrs #(
  parameter int IDX_W  = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  cnt_i,
  input  logic              len_wr_i,
  input  logic              head_wr_i,
  input  logic              tail_wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              frame_i,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic              avail_o,
  output logic              take_o,
  output logic              drop_o,
  output logic [MISS_W-1:0] miss_o
);
  logic [IDX_W-1:0]  head_q, tail_q, head_inc;
  logic [MISS_W-1:0] miss_q;
  logic              drop_q, miss_now;

  assign avail_o  = en_i && head_q != tail_q;
  assign take_o   = frame_i && avail_o;
  assign miss_now = frame_i && en_i && head_q == tail_q;
  assign head_inc = (head_q == cnt_i - 1'b1) ? '0 : head_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      miss_q <= '0;
      drop_q <= 1'b0;
    end else begin
      drop_q <= miss_now;
      if (miss_now) miss_q <= miss_q + 1'b1;
      if (len_wr_i) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        if (head_wr_i) head_q <= wr_idx_i;
        else if (take_o) head_q <= head_inc;
        if (tail_wr_i) tail_q <= wr_idx_i;
      end
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign drop_o = drop_q;
  assign miss_o = miss_q;

  // R8
  head_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i != '0) |-> head_q < cnt_i);
  // R9
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_now |=> (drop_q && miss_q == $past(miss_q) + 1'b1 && head_q == $past(head_q)));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !len_wr_i && !head_wr_i) |=> ($stable(head_q) && !drop_q));
endmodule

// File: rtl/rx_ring_wb.sv
module rx_ring_wb
  import rx_ring_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [63:0]      base_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [15:0]      len_i,
  input  logic [15:0]      csum_i,
  input  logic [7:0]       status_i,
  input  logic [7:0]       err_i,
  input  logic [15:0]      vlan_i,
  output logic [63:0]      desc_addr_o,
  output logic             wb_valid_o,
  output logic [63:0]      wb_addr_o,
  output logic [63:0]      wb_data_o
);
  wb_rec_t rec;
  logic    valid_q;
  logic [63:0] addr_q, data_q;

  assign desc_addr_o = base_i + 64'({head_i, 4'b0000});

  always_comb begin
    rec.length = len_i;
    rec.csum   = csum_i;
    rec.status = status_i | STAT_FORCE_SET;
    rec.errors = err_i & ERR_KEEP_MASK;
    rec.vlan   = vlan_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= take_i;
      if (take_i) begin
        addr_q <= desc_addr_o + 64'd8;
        data_q <= rec;
      end
    end
  end

  assign wb_valid_o = valid_q;
  assign wb_addr_o  = addr_q;
  assign wb_data_o  = data_q;

  // R6
  wb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (wb_valid_o && wb_addr_o[3:0] == 4'h8));
  // R6
  wb_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(take_i));
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int IDX_W  = 16,
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              frame_valid_i,
  input  logic [15:0]       frame_len_i,
  input  logic [15:0]       frame_csum_i,
  input  logic [7:0]        frame_status_i,
  input  logic [7:0]        frame_err_i,
  input  logic [15:0]       frame_vlan_i,
  output logic [63:0]       desc_addr_o,
  output logic              desc_avail_o,
  output logic              wb_valid_o,
  output logic [63:0]       wb_addr_o,
  output logic [63:0]       wb_data_o,
  output logic              drop_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  logic             en, len_wr, head_wr, tail_wr, take;
  logic [63:0]      base;
  logic [IDX_W-1:0] cnt, wr_idx, head, tail;

  rx_ring_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .head_i(head), .tail_i(tail),
    .en_o(en), .base_o(base), .cnt_o(cnt),
    .len_wr_o(len_wr), .head_wr_o(head_wr), .tail_wr_o(tail_wr), .wr_idx_o(wr_idx)
  );

  rx_ring_ptrs #(.IDX_W(IDX_W), .MISS_W(MISS_W)) u_ptrs (
    .clk_i, .rst_ni,
    .en_i(en), .cnt_i(cnt), .len_wr_i(len_wr), .head_wr_i(head_wr), .tail_wr_i(tail_wr),
    .wr_idx_i(wr_idx), .frame_i(frame_valid_i),
    .head_o(head), .tail_o(tail), .avail_o(desc_avail_o), .take_o(take),
    .drop_o(drop_o), .miss_o(miss_cnt_o)
  );

  rx_ring_wb #(.IDX_W(IDX_W)) u_wb (
    .clk_i, .rst_ni,
    .take_i(take), .base_i(base), .head_i(head),
    .len_i(frame_len_i), .csum_i(frame_csum_i), .status_i(frame_status_i),
    .err_i(frame_err_i), .vlan_i(frame_vlan_i),
    .desc_addr_o(desc_addr_o), .wb_valid_o(wb_valid_o),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  // R12
  tail_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && en && head == tail && tail_wr) |=> (drop_o && !wb_valid_o));
endmodule

// File: tb/rx_ring_engine_bench.sv
module rx_ring_engine_bench;
  localparam int IDX_W = 6;
  localparam int MISS_W = 16;

  logic clk = 0, rst_n = 0;
  logic we = 0, fv = 0;
  logic [15:0] addr = 0, f_len = 0, f_csum = 0, f_vlan = 0;
  logic [31:0] wdata = 0;
  logic [7:0]  f_stat = 0, f_err = 0;
  logic [31:0] rdata;
  logic [63:0] desc_addr, wb_addr, wb_data;
  logic desc_avail, wb_valid, drop;
  logic [MISS_W-1:0] miss;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_head = 0, exp_tail = 0, exp_miss = 0, cnt = 0;
  bit exp_en = 0;
  logic [63:0] exp_base = 0;

  rx_ring_engine #(.IDX_W(IDX_W), .MISS_W(MISS_W)) u_rx_ring_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .frame_valid_i(fv), .frame_len_i(f_len), .frame_csum_i(f_csum),
    .frame_status_i(f_stat), .frame_err_i(f_err), .frame_vlan_i(f_vlan),
    .desc_addr_o(desc_addr), .desc_avail_o(desc_avail),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .drop_o(drop), .miss_cnt_o(miss)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, 64'(rdata), 64'(exp));
  endtask

  task automatic frame(input int k);
    bit acc;
    logic [63:0] exp_d;
    @(negedge clk);
    acc = exp_en && exp_head != exp_tail;
    fv = 1;
    f_len = 16'(60 + k * 37); f_csum = 16'(16'hA5A5 ^ (k * 16'h0101));
    f_stat = 8'(8'hFC ^ (k * 8'h44)); f_err = 8'(8'h18 | (k * 8'h21));
    f_vlan = 16'(k * 16'h0123);
    exp_d = {f_vlan, f_err & 8'hE7, f_stat | 8'h03, f_csum, f_len};
    #1;
    chk(desc_avail == acc, "R11 avail", 64'(desc_avail), 64'(acc));
    chk(desc_addr == exp_base + 64'(exp_head) * 16, "R11 desc_addr", desc_addr,
        exp_base + 64'(exp_head) * 16);
    @(negedge clk);
    fv = 0;
    chk(wb_valid == acc, acc ? "R6 accept" : "R9/R10 no write-back", 64'(wb_valid), 64'(acc));
    if (acc) begin
      chk(wb_addr == exp_base + 64'(exp_head) * 16 + 8, "R6 wb_addr", wb_addr,
          exp_base + 64'(exp_head) * 16 + 8);
      chk(wb_data == exp_d, "R7 wb_data", wb_data, exp_d);
      exp_head = (exp_head + 1) % cnt;  // R8 wrap
    end else if (exp_en) begin
      exp_miss++;
    end
    chk(drop == (exp_en && !acc), exp_en ? "R9 drop" : "R10 drop", 64'(drop), 64'(exp_en && !acc));
    chk(miss == MISS_W'(exp_miss), "R9 miss count", 64'(miss), 64'(exp_miss));
    rd(16'h2810, 32'(exp_head), "R8 head readback");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk(!wb_valid && !drop && !desc_avail && miss == 0, "R1 outputs", {wb_valid, drop, desc_avail}, 0);
    rd(16'h0100, 0, "R1 ctrl");
    rd(16'h2808, 0, "R1 len");
    rd(16'h2810, 0, "R1 head");
    rd(16'h2818, 0, "R1 tail");
    rd(16'h1234, 0, "R2 unmapped");

    for (int blk = 1; blk <= 3; blk++) begin
      cnt = blk * 8;
      wr(16'h0100, 0); exp_en = 0;
      exp_base = {32'h0000_00A0 + 32'(blk), 32'h1234_5670 + 32'(blk) * 32'h100};
      wr(16'h2800, exp_base[31:0] | 32'h5);
      wr(16'h2804, exp_base[63:32]);
      wr(16'h2810, 2);                        // R3: head moved, then cleared by length write
      wr(16'h2808, 32'(blk * 128) | 32'h7F);
      exp_head = 0; exp_tail = 0;
      rd(16'h2800, exp_base[31:0], "R2 base_lo");
      rd(16'h2804, exp_base[63:32], "R2 base_hi");
      rd(16'h2808, 32'(blk * 128), "R2 len");
      rd(16'h2810, 0, "R3 head cleared");
      wr(16'h2808, 64);
      rd(16'h2808, 32'(blk * 128), "R3 short length ignored");
      wr(16'h2818, 32'(cnt));
      rd(16'h2818, 0, "R5 tail out of range");
      wr(16'h2810, 32'(cnt + 1));
      rd(16'h2810, 0, "R5 head out of range");
      wr(16'h2810, 32'(cnt - 3)); exp_head = cnt - 3;
      rd(16'h2810, 32'(exp_head), "R5 head legal");
      frame(99);                              // R10 disabled
      wr(16'h2818, 32'(cnt - 4)); exp_tail = cnt - 4;
      wr(16'h0100, 2); exp_en = 1;
      rd(16'h0100, 2, "R2 ctrl enable");
      wr(16'h2800, 32'hFFFF_FFF0);
      wr(16'h2804, 32'hFFFF_FFFF);
      wr(16'h2808, 128 * 7);
      wr(16'h2810, 1);
      rd(16'h2800, exp_base[31:0], "R4 base_lo locked");
      rd(16'h2804, exp_base[63:32], "R4 base_hi locked");
      rd(16'h2808, 32'(blk * 128), "R4 len locked");
      rd(16'h2810, 32'(exp_head), "R4 head locked");
      for (int k = 0; k < cnt; k++) frame(k + blk * 40);   // R8 wrap then R9 drain
      // R12: tail write races a frame on an empty ring
      @(negedge clk);
      we = 1; addr = 16'h2818; wdata = 32'((exp_tail + 2) % cnt); fv = 1;
      @(negedge clk);
      we = 0; fv = 0;
      exp_miss++;
      exp_tail = (exp_tail + 2) % cnt;
      chk(drop && !wb_valid, "R12 judged on old tail", {drop, wb_valid}, 2'b10);
      chk(miss == MISS_W'(exp_miss), "R12 miss count", 64'(miss), 64'(exp_miss));
      rd(16'h2818, 32'(exp_tail), "R4 tail written while enabled");
      frame(7 + blk);
      frame(8 + blk);
      frame(9 + blk);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule